// File: doc/BRIEF.md
# Receive Prefetch Buffer

This block buffers received words on the receive side of a serial link controller. A loader pushes each received word together with a flag that says whether its parity check passed. Words go into a data FIFO. A four-stage prefetch chain pulls them out of that FIFO on its own and moves them toward the host read port, so the oldest word is already waiting when the host asks for it. Nothing from the host is needed for a word to move forward.

The host sees two kinds of fill information. The empty, almost-full and full flags describe the data FIFO only and take no account of the prefetch chain, so the FIFO can read as empty while words are still waiting in the chain. A word count adds FIFO occupancy and valid chain stages together, and the host can use it to size a burst of reads. Two sticky error bits record an overflow (a loader write that arrives while the FIFO is full) and a parity failure. Each bit is a two-state machine: `ERR_IDLE` goes to `ERR_LATCHED` on its event. `ERR_LATCHED` goes back to `ERR_IDLE` when the host writes a 1 to that bit and no new event arrives in the same cycle. In every other case it stays put.

A small companion FIFO holds one length per received packet and reports its own empty and full flags.

Top module: `rx_prefetch_buffer`

## Requirements
- R1: After reset, flag_empty=1, flag_full=0, flag_afull=0, word_count=0, rd_valid=0, err_overflow=0, err_parity=0, len_empty=1 and len_full=0.
- R2: Words reach rd_data in the order they were written. A word written at clock edge k into an empty block shows rd_valid=1 after edge k+4 and not before.
- R3: A loader write while flag_full=1 sets err_overflow at the next edge and discards the word, so word_count does not rise.
- R4: flag_empty reflects the data FIFO only. One edge after a lone word is written into an empty block, that word has moved into the chain, so flag_empty=1 while word_count=1.
- R5: word_count equals FIFO occupancy plus valid chain stages, which is the number of accepted words not yet read. Its maximum is 20 with the default 16-deep FIFO and 4 stages.
- R6: flag_afull=1 exactly when FIFO occupancy is strictly greater than afull_level. With a level of 3, an occupancy of 3 gives 0 and an occupancy of 4 gives 1.
- R7: flag_full=1 exactly when the FIFO holds 16 words. With the chain full as well, word_count reads 20.
- R8: A loader write with ld_par_ok=0 sets err_parity at the next edge. The word is still stored.
- R9: stat_wr with a 1 in stat_wdata bit 0 clears err_overflow, and a 1 in bit 1 clears err_parity. A 0 in a bit leaves that error bit unchanged.
- R10: When a clear and a new error event hit the same bit in the same cycle, the bit stays at 1.
- R11: The length FIFO (4 entries) returns lengths in push order on len_head. len_full=1 when it holds 4 entries, a push while full is dropped, and len_empty=1 when it holds none.
- R12: rd_en while rd_valid=0 has no effect on word_count or on later data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Loader write strobe |
| ld_data | input | DATA_W | Received word |
| ld_par_ok | input | 1 | 1 when the word's parity check passed |
| rd_en | input | 1 | Host takes the head word |
| rd_data | output | DATA_W | Head word of the prefetch chain |
| rd_valid | output | 1 | rd_data holds a word |
| afull_level | input | $clog2(DEPTH+1) | Almost-full threshold |
| flag_empty | output | 1 | Data FIFO holds no words |
| flag_afull | output | 1 | Data FIFO occupancy above afull_level |
| flag_full | output | 1 | Data FIFO cannot accept a word |
| word_count | output | $clog2(DEPTH+STAGES+1) | FIFO plus chain word count |
| stat_wr | input | 1 | Host write to the error bits |
| stat_wdata | input | 2 | Bit 0 clears overflow, bit 1 clears parity |
| err_overflow | output | 1 | Sticky overflow bit |
| err_parity | output | 1 | Sticky parity-error bit |
| len_push | input | 1 | Store a packet length |
| len_data | input | LEN_W | Packet length to store |
| len_pop | input | 1 | Remove the oldest length |
| len_head | output | LEN_W | Oldest stored length |
| len_empty | output | 1 | Length FIFO empty |
| len_full | output | 1 | Length FIFO full |

## Verification
A fault in a FIFO pointer or in the chain's move logic shows up as a wrong word, or a repeated word, on rd_data at the next host read. A lost or doubled level update shows at once in word_count, because the bench compares the count with its own model after every edge. A chain that stalls or skips a stage moves the first rd_valid away from the fourth edge after a write. A sticky bit whose state machine has the wrong set/clear priority gives a wrong error bit one edge after the write that caused it.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
    typedef enum logic {
        ERR_IDLE,
        ERR_LATCHED
    } err_state_e;

    localparam int STAT_OVF_BIT = 0;
    localparam int STAT_PAR_BIT = 1;
endpackage

// File: rtl/rxb_fifo.sv
module rxb_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] level
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          do_push;
    logic          do_pop;

    assign do_push = push && (level != CW'(DEPTH));
    assign do_pop  = pop  && (level != '0);
    assign dout    = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   level <= level + CW'(1);
                2'b01:   level <= level - CW'(1);
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/rxb_prefetch.sv
module rxb_prefetch #(
    parameter int W      = 8,
    parameter int STAGES = 4,
    localparam int PW = $clog2(STAGES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          src_valid,
    input  logic [W-1:0]  src_data,
    output logic          src_take,
    input  logic          out_take,
    output logic          out_valid,
    output logic [W-1:0]  out_data,
    output logic [PW-1:0] occ
);
    logic [STAGES-1:0] v;
    logic [STAGES-1:0] mv;
    logic [W-1:0]      d [STAGES];

    // Stage 0 is the read port; a stage moves down when the one below is free or moving.
    always_comb begin
        mv[0] = v[0] && out_take;
        for (int i = 1; i < STAGES; i++) begin
            mv[i] = v[i] && (!v[i-1] || mv[i-1]);
        end
    end

    assign src_take  = src_valid && (!v[STAGES-1] || mv[STAGES-1]);
    assign out_valid = v[0];
    assign out_data  = d[0];

    always_comb begin
        occ = '0;
        for (int i = 0; i < STAGES; i++) begin
            occ = occ + PW'(v[i]);
        end
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic          fill;
        logic [W-1:0]  fill_data;
        if (g == STAGES - 1) begin : g_top
            assign fill      = src_take;
            assign fill_data = src_data;
        end else begin : g_mid
            assign fill      = mv[g+1];
            assign fill_data = d[g+1];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v[g] <= 1'b0;
            end else begin
                v[g] <= fill || (v[g] && !mv[g]);
            end
        end

        always_ff @(posedge clk) begin
            if (fill) d[g] <= fill_data;
        end
    end
endmodule

// File: rtl/rxb_sticky.sv
module rxb_sticky
    import rxb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic clr_req,
    output logic flag
);
    err_state_e state;
    err_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ERR_IDLE:    if (set_ev) state_nx = ERR_LATCHED;
            ERR_LATCHED: if (clr_req && !set_ev) state_nx = ERR_IDLE;
            default:     state_nx = ERR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ERR_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        flag = (state == ERR_LATCHED);
    end
endmodule

// File: rtl/rx_prefetch_buffer.sv
module rx_prefetch_buffer
    import rxb_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int DEPTH     = 16,
    parameter int STAGES    = 4,
    parameter int LEN_W     = 8,
    parameter int LEN_DEPTH = 4,
    localparam int AW    = $clog2(DEPTH + 1),
    localparam int CNT_W = $clog2(DEPTH + STAGES + 1),
    localparam int PW    = $clog2(STAGES + 1),
    localparam int LCW   = $clog2(LEN_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              ld_par_ok,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic [AW-1:0]     afull_level,
    output logic              flag_empty,
    output logic              flag_afull,
    output logic              flag_full,
    output logic [CNT_W-1:0]  word_count,
    input  logic              stat_wr,
    input  logic [1:0]        stat_wdata,
    output logic              err_overflow,
    output logic              err_parity,
    input  logic              len_push,
    input  logic [LEN_W-1:0]  len_data,
    input  logic              len_pop,
    output logic [LEN_W-1:0]  len_head,
    output logic              len_empty,
    output logic              len_full
);
    logic [AW-1:0]     fifo_level;
    logic [DATA_W-1:0] fifo_head;
    logic              fifo_pop;
    logic [PW-1:0]     pipe_occ;
    logic [LCW-1:0]    len_level;

    rxb_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_data_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (ld_valid),
        .din   (ld_data),
        .pop   (fifo_pop),
        .dout  (fifo_head),
        .level (fifo_level)
    );

    rxb_prefetch #(.W(DATA_W), .STAGES(STAGES)) u_prefetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_valid (!flag_empty),
        .src_data  (fifo_head),
        .src_take  (fifo_pop),
        .out_take  (rd_en),
        .out_valid (rd_valid),
        .out_data  (rd_data),
        .occ       (pipe_occ)
    );

    rxb_sticky u_ovf (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_ev  (ld_valid && flag_full),
        .clr_req (stat_wr && stat_wdata[STAT_OVF_BIT]),
        .flag    (err_overflow)
    );

    rxb_sticky u_par (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_ev  (ld_valid && !ld_par_ok),
        .clr_req (stat_wr && stat_wdata[STAT_PAR_BIT]),
        .flag    (err_parity)
    );

    rxb_fifo #(.W(LEN_W), .DEPTH(LEN_DEPTH)) u_len_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (len_push),
        .din   (len_data),
        .pop   (len_pop),
        .dout  (len_head),
        .level (len_level)
    );

    assign flag_empty = (fifo_level == '0);
    assign flag_full  = (fifo_level == AW'(DEPTH));
    assign flag_afull = (fifo_level > afull_level);
    assign word_count = CNT_W'(fifo_level) + CNT_W'(pipe_occ);
    assign len_empty  = (len_level == '0);
    assign len_full   = (len_level == LCW'(LEN_DEPTH));
endmodule

// File: rtl/rxb_checker.sv
module rxb_checker #(
    parameter int DEPTH  = 16,
    parameter int STAGES = 4,
    localparam int CNT_W = $clog2(DEPTH + STAGES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ld_valid,
    input logic             ld_par_ok,
    input logic             rd_en,
    input logic             rd_valid,
    input logic             flag_empty,
    input logic             flag_afull,
    input logic             flag_full,
    input logic [CNT_W-1:0] word_count,
    input logic             stat_wr,
    input logic [1:0]       stat_wdata,
    input logic             err_overflow,
    input logic             err_parity,
    input logic             len_empty,
    input logic             len_full
);
    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        word_count <= CNT_W'(DEPTH + STAGES));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid && flag_full |=> err_overflow);

    assert_drop_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid && flag_full && !(rd_en && rd_valid) |=> word_count == $past(word_count));

    assert_full_not_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_full |-> !flag_empty);

    assert_empty_not_afull_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flag_empty |-> !flag_afull);

    assert_parity_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_parity && !(stat_wr && stat_wdata[1]) |=> err_parity);

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid && !ld_par_ok |=> err_parity);

    assert_clear_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_overflow) |-> $past(stat_wr && stat_wdata[0]));

    assert_len_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
        len_full |-> !len_empty);
endmodule

bind rx_prefetch_buffer rxb_checker #(.DEPTH(DEPTH), .STAGES(STAGES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ld_valid     (ld_valid),
    .ld_par_ok    (ld_par_ok),
    .rd_en        (rd_en),
    .rd_valid     (rd_valid),
    .flag_empty   (flag_empty),
    .flag_afull   (flag_afull),
    .flag_full    (flag_full),
    .word_count   (word_count),
    .stat_wr      (stat_wr),
    .stat_wdata   (stat_wdata),
    .err_overflow (err_overflow),
    .err_parity   (err_parity),
    .len_empty    (len_empty),
    .len_full     (len_full)
);

// File: tb/tb_rx_prefetch_buffer.sv
module tb_rx_prefetch_buffer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ld_valid;
    logic [7:0] ld_data;
    logic       ld_par_ok;
    logic       rd_en;
    logic [7:0] rd_data;
    logic       rd_valid;
    logic [4:0] afull_level;
    logic       flag_empty, flag_afull, flag_full;
    logic [4:0] word_count;
    logic       stat_wr;
    logic [1:0] stat_wdata;
    logic       err_overflow, err_parity;
    logic       len_push, len_pop;
    logic [7:0] len_data, len_head;
    logic       len_empty, len_full;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_prefetch_buffer dut (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_data(ld_data),
        .ld_par_ok(ld_par_ok), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
        .afull_level(afull_level), .flag_empty(flag_empty), .flag_afull(flag_afull),
        .flag_full(flag_full), .word_count(word_count), .stat_wr(stat_wr),
        .stat_wdata(stat_wdata), .err_overflow(err_overflow), .err_parity(err_parity),
        .len_push(len_push), .len_data(len_data), .len_pop(len_pop),
        .len_head(len_head), .len_empty(len_empty), .len_full(len_full)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Occupancy of the data FIFO once the chain has settled with no reads.
    function automatic int settled_fifo(input int words);
        return (words > 4) ? words - 4 : 0;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet();
        ld_valid = 0; ld_par_ok = 1; ld_data = 0; rd_en = 0;
        stat_wr = 0; stat_wdata = 0; len_push = 0; len_pop = 0; len_data = 0;
    endtask

    task automatic do_reset();
        quiet();
        rst_n = 0;
        repeat (3) step();
        rst_n = 1;
        step();
    endtask

    task automatic write_words(input int first, input int n);
        for (int i = 0; i < n; i++) begin
            ld_valid = 1; ld_par_ok = 1; ld_data = 8'(first + i);
            step();
        end
        ld_valid = 0;
    endtask

    task automatic drain(input string req, input int first, input int n);
        int got = 0;
        int guard = 0;
        while (got < n && guard < 400) begin
            if (rd_valid) begin
                check(req, rd_data, (first + got) & 8'hFF);
                rd_en = 1;
                got++;
            end else begin
                rd_en = 0;
            end
            step();
            guard++;
        end
        rd_en = 0;
        check(req, got, n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL R2 watchdog actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        afull_level = 5'd3;
        do_reset();

        // R1: reset state
        check("R1 flag_empty", flag_empty, 1);
        check("R1 flag_full", flag_full, 0);
        check("R1 flag_afull", flag_afull, 0);
        check("R1 word_count", word_count, 0);
        check("R1 rd_valid", rd_valid, 0);
        check("R1 err_overflow", err_overflow, 0);
        check("R1 err_parity", err_parity, 0);
        check("R1 len_empty", len_empty, 1);
        check("R1 len_full", len_full, 0);

        // R12: read with nothing valid
        rd_en = 1; step(); rd_en = 0;
        check("R12 count after empty read", word_count, 0);
        check("R12 rd_valid after empty read", rd_valid, 0);

        // R2/R4/R5: latency of a single word
        ld_valid = 1; ld_data = 8'hA5; step(); ld_valid = 0;
        check("R4 fifo holds word", flag_empty, 0);
        check("R5 count one", word_count, 1);
        step();
        check("R4 fifo empty while chain holds word", flag_empty, 1);
        check("R4 count still one", word_count, 1);
        check("R2 not yet valid k+1", rd_valid, 0);
        step(); step();
        check("R2 not yet valid k+3", rd_valid, 0);
        step();
        check("R2 valid at k+4", rd_valid, 1);
        check("R2 data", rd_data, 8'hA5);
        check("R12 data intact after empty read", rd_data, 8'hA5);
        rd_en = 1; step(); rd_en = 0;
        check("R5 count zero after read", word_count, 0);

        // R6: strict greater-than compare, level 3
        write_words(0, 7);
        repeat (8) step();
        check("R5 count seven", word_count, 7);
        check("R6 occ 3 not afull", flag_afull, (settled_fifo(7) > 3) ? 1 : 0);
        check("R4 fifo not empty", flag_empty, 0);
        write_words(7, 1);
        repeat (8) step();
        check("R6 occ 4 afull", flag_afull, (settled_fifo(8) > 3) ? 1 : 0);

        // R7: fill to the top
        write_words(8, 12);
        repeat (8) step();
        check("R7 flag_full", flag_full, 1);
        check("R7 count twenty", word_count, 20);
        check("R6 afull when full", flag_afull, 1);

        // R3: overflow write
        ld_valid = 1; ld_data = 8'hEE; step(); ld_valid = 0;
        check("R3 err_overflow set", err_overflow, 1);
        check("R3 count unchanged", word_count, 20);
        drain("R2 order after fill", 0, 20);
        repeat (2) step();
        check("R3 dropped word absent", word_count, 0);
        check("R7 full cleared", flag_full, 0);
        check("R4 empty after drain", flag_empty, 1);

        // R9: clear semantics
        stat_wr = 1; stat_wdata = 2'b00; step(); stat_wr = 0;
        check("R9 write 0 keeps overflow", err_overflow, 1);
        stat_wr = 1; stat_wdata = 2'b10; step(); stat_wr = 0;
        check("R9 parity clear keeps overflow", err_overflow, 1);
        stat_wr = 1; stat_wdata = 2'b01; step(); stat_wr = 0;
        check("R9 write 1 clears overflow", err_overflow, 0);

        // R8/R10: parity sticky and set priority
        ld_valid = 1; ld_par_ok = 0; ld_data = 8'h30; step(); ld_valid = 0; ld_par_ok = 1;
        check("R8 parity set", err_parity, 1);
        check("R8 word stored", word_count, 1);
        repeat (3) step();
        check("R8 parity sticky", err_parity, 1);
        ld_valid = 1; ld_par_ok = 0; ld_data = 8'h31; stat_wr = 1; stat_wdata = 2'b10;
        step();
        ld_valid = 0; ld_par_ok = 1; stat_wr = 0;
        check("R10 set beats clear", err_parity, 1);
        stat_wr = 1; stat_wdata = 2'b10; step(); stat_wr = 0;
        check("R9 parity cleared", err_parity, 0);
        drain("R8 bad-parity words delivered", 8'h30, 2);

        // R11: length FIFO
        for (int i = 0; i < 4; i++) begin
            len_push = 1; len_data = 8'(10 * (i + 1)); step();
        end
        len_push = 0;
        check("R11 len_full", len_full, 1);
        check("R11 len not empty", len_empty, 0);
        len_push = 1; len_data = 8'd99; step(); len_push = 0;
        for (int i = 0; i < 4; i++) begin
            check("R11 len order", len_head, 10 * (i + 1));
            len_pop = 1; step(); len_pop = 0;
        end
        check("R11 len_empty after pops", len_empty, 1);
        check("R11 len_full after pops", len_full, 0);

        // R2/R5/R8/R9/R12: random traffic against a queue model
        begin
            int q[$];
            bit exp_par;
            bit rd, wr, badp, clr;
            int seed_val;
            do_reset();
            seed_val = $urandom(32'd4242);
            exp_par = 0;
            for (int c = 0; c < 3000; c++) begin
                check("R5 random count", word_count, q.size());
                check("R8 random parity", err_parity, exp_par);
                rd   = ($urandom % 2 == 0);
                wr   = (q.size() < 14) && ($urandom % 3 != 0);
                badp = ($urandom % 16 == 0);
                clr  = ($urandom % 8 == 0);
                if (rd && rd_valid) begin
                    check("R2 random order", rd_data, q[0]);
                    void'(q.pop_front());
                end
                rd_en      = rd;
                ld_valid   = wr;
                ld_data    = 8'($urandom);
                ld_par_ok  = !badp;
                stat_wr    = clr;
                stat_wdata = 2'b10;
                if (wr) q.push_back(int'(ld_data));
                exp_par = (exp_par && !clr) || (wr && badp);
                step();
            end
            quiet();
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule